// File: doc/BRIEF.md
# Narrow Pulse Rejection Filter

This block is a clocked filter for one single-bit pulse input. It passes only those pulses that stay high for more than a programmable number of clock cycles. Shorter pulses are removed completely. A timer starts on every rising edge of the input. When the pulse has lasted past the threshold, the output goes high, and it stays high until the input goes low.

Only the leading edge of an accepted pulse is delayed, and the delay is the threshold. The trailing edge follows the input with one register stage. So every accepted pulse comes out shorter by exactly the threshold. When the filter drops a pulse, it raises a one-cycle strobe so that the logic downstream can count glitches. Typical uses are removing spikes from a slow control line and checking a pulse-width qualifier. The input is assumed to be synchronous to the clock already.

Top module: `pulse_width_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pulse_out` and `reject_stb` are both 0.
- R2: An input pulse of W high samples with W <= `thresh` (including W equal to `thresh`) produces no output: `pulse_out` stays 0 for the whole pulse.
- R3: An input pulse of W high samples with W > `thresh` drives `pulse_out` high for exactly W - `thresh` consecutive cycles; W = `thresh` + 1 gives a single-cycle output.
- R4: The leading edge of an accepted output appears after the clock edge that samples the (`thresh`+1)-th consecutive high input cycle.
- R5: `pulse_out` goes low after the first clock edge that samples the input low.
- R6: After a rejected pulse, `reject_stb` is 1 for exactly one cycle, after the edge that samples the input low. It is never raised for an accepted pulse, and it is never high together with `pulse_out`.
- R7: With `thresh` = 0, `pulse_out` equals the input delayed by one clock cycle, and `reject_stb` stays 0.
- R8: The run timer saturates. With `thresh` at its maximum value (2^`CNT_W` - 1), a longer pulse is still accepted, and the output stays high until the input falls.
- R9: Each new rising edge restarts the timer. A single low cycle between two short pulses clears the accumulated width, so the two pulses are never added together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| thresh | input | CNT_W | Rejection threshold in clock cycles, held stable during a pulse |
| pulse_in | input | 1 | Synchronous pulse input |
| pulse_out | output | 1 | Filtered pulse output |
| reject_stb | output | 1 | One-cycle strobe that marks a dropped pulse |

## Verification
The bench builds the block with its default `CNT_W` of 8. At this width the saturation point of the timer (threshold 255) can be reached in a few hundred cycles, so a pulse 300 cycles long exercises the maximum threshold next to small thresholds of 0, 4 and 5. The small thresholds put the equal-width and one-longer boundaries and the one-cycle gap between pulses within a few cycles of each other.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARM  = 2'd1,
        PH_PASS = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   pass;
        logic   rej;
    } fsm_reg_t;

endpackage

// File: rtl/pwg_run_timer.sv
module pwg_run_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_reg_t;

    timer_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!din) begin
            r_d.cnt = '0;
        end else if (r_q.cnt != CMAX) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
        // hit: this sample is at least the (limit+1)-th high one
        hit = din && (r_q.cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R9
    timer_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !din |=> (r_q.cnt == '0));
    // R8
    timer_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din && r_q.cnt == CMAX) |=> (r_q.cnt == CMAX));
endmodule

// File: rtl/pwg_phase_fsm.sv
module pwg_phase_fsm
    import pwg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic hit,
    output logic pass_o,
    output logic rej_o
);
    fsm_reg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.rej = 1'b0;
        if (!din) begin
            s_d.phase = PH_IDLE;
            s_d.pass  = 1'b0;
            s_d.rej   = (s_q.phase == PH_ARM);
        end else if (s_q.phase == PH_PASS) begin
            s_d.pass = 1'b1;
        end else if (hit) begin
            s_d.phase = PH_PASS;
            s_d.pass  = 1'b1;
        end else begin
            s_d.phase = PH_ARM;
            s_d.pass  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, pass: 1'b0, rej: 1'b0};
        else        s_q <= s_d;
    end

    assign pass_o = s_q.pass;
    assign rej_o  = s_q.rej;

    // R6
    rej_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej_o |=> !rej_o);
    // R6
    rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rej_o && pass_o));
endmodule

// File: rtl/pulse_width_gate.sv
module pulse_width_gate #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] thresh,
    input  logic             pulse_in,
    output logic             pulse_out,
    output logic             reject_stb
);
    logic hit;

    pwg_run_timer #(.CW(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pulse_in),
        .limit (thresh),
        .hit   (hit)
    );

    pwg_phase_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pulse_in),
        .hit    (hit),
        .pass_o (pulse_out),
        .rej_o  (reject_stb)
    );

    // R4
    out_needs_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(pulse_in));
    // R5
    out_follows_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_in |=> !pulse_out);
    // R7
    zero_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh == '0 && pulse_in) |=> pulse_out);
endmodule

// File: tb/pulse_width_gate_bench.sv
module pulse_width_gate_bench;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] thresh = '0;
    logic          pulse_in = 1'b0;
    logic          pulse_out, reject_stb;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic  d;
        logic  r;
        string tag;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    pulse_width_gate #(.CNT_W(CW)) u_pulse_width_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .thresh     (thresh),
        .pulse_in   (pulse_in),
        .pulse_out  (pulse_out),
        .reject_stb (reject_stb)
    );

    task automatic check(input logic d, input logic r, input string tag);
        total++;
        if (pulse_out !== d || reject_stb !== r) begin
            bad++;
            $display("FAIL %s: out=%b rej=%b expected out=%b rej=%b at %0t",
                     tag, pulse_out, reject_stb, d, r, $time);
        end
    endtask

    // monitor: compare after every edge at which an item is pending
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.d, e.r, e.tag);
            end
        end
    end

    // one driven cycle; expected value refers to the state after the next edge
    task automatic step(input logic v, input logic d, input logic r, input string tag);
        @(negedge clk);
        pulse_in = v;
        @(posedge clk);
        q.push_back('{d: d, r: r, tag: tag});
    endtask

    // pulse of w high samples followed by gap low samples, threshold t
    task automatic pulse(input int w, input int gap, input int t, input string acc_tag);
        for (int i = 0; i < w; i++) begin
            if (i >= t) step(1'b1, 1'b1, 1'b0, (i == t) ? "R4" : acc_tag);
            else        step(1'b1, 1'b0, 1'b0, "R2");
        end
        for (int i = 0; i < gap; i++) begin
            if (i == 0) step(1'b0, 1'b0, (w <= t) ? 1'b1 : 1'b0, (w <= t) ? "R6" : "R5");
            else        step(1'b0, 1'b0, 1'b0, "R6");
        end
    endtask

    task automatic set_thresh(input int t);
        @(negedge clk);
        thresh = t[CW-1:0];
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(1'b0, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check(1'b0, 1'b0, "R1");

        set_thresh(5);
        pulse(3, 3, 5, "R3");     // R2 short
        pulse(5, 3, 5, "R3");     // R2 equal width rejected
        pulse(6, 3, 5, "R3");     // R3 one-cycle output
        pulse(12, 4, 5, "R3");    // R3 width 7, R5 trailing edge

        set_thresh(0);
        pulse(1, 2, 0, "R7");     // R7 one-cycle follow
        pulse(4, 1, 0, "R7");
        pulse(2, 3, 0, "R7");

        set_thresh(4);
        pulse(3, 1, 4, "R9");     // R9 two short pulses split by one low cycle
        pulse(3, 3, 4, "R9");
        pulse(3, 1, 4, "R9");
        pulse(6, 3, 4, "R9");     // R9 restart then accept

        set_thresh(255);
        pulse(255, 2, 255, "R8"); // R8 equal to max rejected
        pulse(300, 3, 255, "R8"); // R8 saturated timer still accepts

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule